// File: doc/BRIEF.md
# Serial-Acknowledge Priority Interrupt Chain

This block gathers interrupt requests from a fixed number of devices that hang off a single shared, active-low request line and a serial acknowledge path. Each device holds a registered pending flag. While any flag is set, the shared line is pulled low. When the processor raises its acknowledge, the acknowledge ripples from the first device towards the last. The first device that has a pending request stops the ripple. It then places its own 8-bit vector on the vector bus and raises a valid strobe.

Position in the chain sets priority: device 0 receives the acknowledge directly and wins over every device behind it. A device's pending flag clears on the first clock edge that sees the acknowledge low again, which marks its vector as consumed. The block exposes the per-device acknowledge-in and acknowledge-out signals so that the ripple can be observed.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A request input sampled high at a rising clock edge makes that device pending from that edge on. The device stays pending after the request input drops, until it is serviced as in R9.
- R2: `irq_n_o` is 0 while at least one device is pending and 1 while none is.
- R3: The acknowledge-in of device 0 equals `ack_i`. The acknowledge-in of device k+1 equals the acknowledge-out of device k.
- R4: A device whose acknowledge-in is 0 drives its acknowledge-out to 0.
- R5: A device whose acknowledge-in is 1 and which is not pending drives its acknowledge-out to 1.
- R6: A device whose acknowledge-in is 1 and which is pending drives its acknowledge-out to 0 and puts its vector on `vec_o`.
- R7: At most one device supplies a vector: the lowest-indexed pending device, while `ack_i` is 1. `vec_valid_o` is 1 exactly when such a device exists.
- R8: While `ack_i` is 0, `vec_o` is all zeros and `vec_valid_o` is 0.
- R9: At a rising edge that samples `ack_i` low after the previous edge sampled it high, the lowest-indexed pending device is cleared. If that device's request input is high at the same edge, the device stays pending, because setting wins over clearing.
- R10: The vector of device k is bits [8k+7:8k] of `VEC_TABLE`. The defaults are 0x40, 0x44, 0x48 and 0x4C for devices 0 to 3.
- R11: Synchronous reset clears all pending flags. After reset `irq_n_o` is 1, `vec_o` is 0 and `vec_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_DEV | Request from each device, bit 0 highest priority |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_n_o | output | 1 | Shared active-low request line |
| pi_o | output | N_DEV | Acknowledge-in seen by each device |
| po_o | output | N_DEV | Acknowledge-out passed on by each device |
| vec_o | output | 8 | Vector of the winning device, zero otherwise |
| vec_valid_o | output | 1 | Vector on `vec_o` is valid |

## Verification
The clocked properties assume that `ack_i` changes only between clock edges. They also assume that the acknowledge stays high long enough for a clock edge to sample it, so that the fall detector in R9 sees it. The bench drives `req_i` and `ack_i` on the falling clock edge and holds the acknowledge for whole cycles. Random requests and acknowledge pulses are therefore always sampled cleanly. Directed cases then cover an acknowledge with nothing pending, all devices requesting together, and a request that coincides with a clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int VEC_W = 8;

    typedef logic [VEC_W-1:0] vec_t;

    // Outputs of one chain stage
    typedef struct packed {
        logic po;
        logic grant;
    } stage_out_t;

    // Pass-through rule of one stage
    function automatic stage_out_t stage_eval(input logic pi, input logic pend);
        stage_out_t r;
        r.po    = pi & ~pend;
        r.grant = pi & pend;
        return r;
    endfunction

endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] req_i,
    input  logic             ack_i,
    output logic [N_DEV-1:0] pend_o
);

    logic [N_DEV-1:0] pend_q;
    logic [N_DEV-1:0] head_sel;
    logic [N_DEV-1:0] clr_mask;
    logic             ack_d;

    // Lowest-indexed pending device: the one whose vector was on the bus
    always_comb begin
        head_sel = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                head_sel    = '0;
                head_sel[i] = 1'b1;
            end
        end
    end

    assign clr_mask = (ack_d && !ack_i) ? head_sel : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            ack_d  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | req_i;
            ack_d  <= ack_i;
        end
    end

    assign pend_o = pend_q;

    // R1
    req_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i)));

    // R9
    served_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_d && !ack_i) |=> ((pend_q & $past(head_sel) & ~$past(req_i)) == '0));

    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_d || ack_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/irqc_stage.sv
module irqc_stage
    import irqc_pkg::*;
(
    input  logic       pi_i,
    input  logic       pend_i,
    output stage_out_t so_o
);

    assign so_o = stage_eval(pi_i, pend_i);

endmodule

// File: rtl/irqc_vec_sel.sv
module irqc_vec_sel
    import irqc_pkg::*;
#(
    parameter int                       N_DEV     = 4,
    parameter logic [N_DEV*VEC_W-1:0]   VEC_TABLE = {8'h4C, 8'h48, 8'h44, 8'h40}
) (
    input  logic [N_DEV-1:0] grant_i,
    output vec_t             vec_o,
    output logic             valid_o
);

    always_comb begin
        vec_o = '0;
        for (int k = 0; k < N_DEV; k++) begin
            if (grant_i[k]) begin
                vec_o = vec_o | VEC_TABLE[k*VEC_W +: VEC_W];
            end
        end
    end

    assign valid_o = |grant_i;

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irqc_pkg::*;
#(
    parameter int                       N_DEV     = 4,
    parameter logic [N_DEV*VEC_W-1:0]   VEC_TABLE = {8'h4C, 8'h48, 8'h44, 8'h40}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] req_i,
    input  logic             ack_i,
    output logic             irq_n_o,
    output logic [N_DEV-1:0] pi_o,
    output logic [N_DEV-1:0] po_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o
);

    logic [N_DEV-1:0] pend;
    logic [N_DEV-1:0] pi_w;
    logic [N_DEV-1:0] po_w;
    logic [N_DEV-1:0] grant_w;
    stage_out_t       so_w [N_DEV];

    irqc_req_bank #(.N_DEV(N_DEV)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .ack_i  (ack_i),
        .pend_o (pend)
    );

    // Shared line: pulled low by any pending device
    assign irq_n_o = ~(|pend);

    for (genvar g = 0; g < N_DEV; g++) begin : g_chain
        if (g == 0) begin : g_head
            assign pi_w[g] = ack_i;
        end else begin : g_link
            assign pi_w[g] = po_w[g-1];
        end
        irqc_stage u_stage (
            .pi_i   (pi_w[g]),
            .pend_i (pend[g]),
            .so_o   (so_w[g])
        );
        assign po_w[g]    = so_w[g].po;
        assign grant_w[g] = so_w[g].grant;
    end

    irqc_vec_sel #(.N_DEV(N_DEV), .VEC_TABLE(VEC_TABLE)) u_vsel (
        .grant_i (grant_w),
        .vec_o   (vec_o),
        .valid_o (vec_valid_o)
    );

    assign pi_o = pi_w;
    assign po_o = po_w;

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_w));

    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_i |-> (vec_o == '0 && !vec_valid_o));

    // R6
    ack_served_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_n_o) |-> vec_valid_o);

    // R5
    full_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && po_o[N_DEV-1]) |-> (irq_n_o && !vec_valid_o));

    // R4
    blocked_tail_chk: assert property (@(posedge clk) disable iff (rst)
        !pi_o[0] |-> (po_o == '0));

endmodule

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req_i;
    logic         ack_i;
    logic         irq_n_o;
    logic [N-1:0] pi_o;
    logic [N-1:0] po_o;
    logic [7:0]   vec_o;
    logic         vec_valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    logic [N-1:0] m_pend;
    logic         m_ack_d;

    always #2 clk = ~clk;

    irq_chain_ctrl u_irq_chain_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .ack_i       (ack_i),
        .irq_n_o     (irq_n_o),
        .pi_o        (pi_o),
        .po_o        (po_o),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    // R10 default vector of device k
    function automatic logic [7:0] exp_vec_of(input int k);
        return 8'h40 + 8'(4 * k);
    endfunction

    function automatic int lowest(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return -1;
    endfunction

    // R3 R4 R5 R6: acknowledge-out of each device
    function automatic logic [N-1:0] exp_po(input logic [N-1:0] p, input logic a);
        logic [N-1:0] r;
        logic in_v;
        in_v = a;
        for (int i = 0; i < N; i++) begin
            r[i] = in_v && !p[i];
            in_v = r[i];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_pi(input logic [N-1:0] p, input logic a);
        logic [N-1:0] po;
        po = exp_po(p, a);
        return {po[N-2:0], a};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        int w;
        w = ack_i ? lowest(m_pend) : -1;
        chk(32'(irq_n_o), 32'(m_pend == '0), "R2 irq_n");
        chk(32'(pi_o), 32'(exp_pi(m_pend, ack_i)), "R3 pi chain");
        chk(32'(po_o), 32'(exp_po(m_pend, ack_i)), "R4 R5 R6 po chain");
        chk(32'(vec_valid_o), 32'(w >= 0), "R7 valid");
        chk(32'(vec_o), (w >= 0) ? 32'(exp_vec_of(w)) : 32'h0, ack_i ? "R6 R10 vector" : "R8 idle vector");
    endtask

    // one clock: drive at falling edge, model at rising edge, sample after it
    task automatic step(input logic [N-1:0] r, input logic a);
        int h;
        @(negedge clk);
        req_i = r;
        ack_i = a;
        @(posedge clk);
        h = lowest(m_pend);
        if (m_ack_d && !a && h >= 0) m_pend[h] = 1'b0;
        m_pend  = m_pend | r;
        m_ack_d = a;
        #1;
        check_outputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_i = '0; ack_i = 1'b0;
        m_pend = '0; m_ack_d = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(32'(irq_n_o), 32'd1, "R11 irq_n after reset");
        chk(32'(vec_o), 32'd0, "R11 vec after reset");
        chk(32'(vec_valid_o), 32'd0, "R11 valid after reset");
        @(negedge clk); rst = 1'b0;

        // acknowledge with nothing pending: whole chain passes (R5)
        step('0, 1'b1);
        chk(32'(po_o), 32'hF, "R5 empty chain passes");
        step('0, 1'b0);

        // R1: pulse then drop, stays pending
        step(4'b0100, 1'b0);
        step(4'b0000, 1'b0);
        chk(32'(irq_n_o), 32'd0, "R1 request held");
        step(4'b0000, 1'b1);
        chk(32'(vec_o), 32'h48, "R10 device 2 vector");
        step(4'b0000, 1'b0);
        chk(32'(irq_n_o), 32'd1, "R9 device 2 cleared");

        // all at once: service in priority order
        step(4'b1111, 1'b0);
        for (int k = 0; k < N; k++) begin
            step('0, 1'b1);
            chk(32'(vec_o), 32'(exp_vec_of(k)), "R7 priority order");
            step('0, 1'b0);
        end
        chk(32'(irq_n_o), 32'd1, "R9 all served");

        // request coinciding with clear: set wins
        step(4'b0010, 1'b0);
        step(4'b0000, 1'b1);
        step(4'b0010, 1'b0);
        chk(32'(irq_n_o), 32'd0, "R9 set wins over clear");
        step(4'b0000, 1'b1);
        step(4'b0000, 1'b0);

        // higher-priority request arriving during acknowledge
        step(4'b1000, 1'b0);
        step(4'b0000, 1'b1);
        step(4'b0001, 1'b1);
        chk(32'(vec_o), 32'h40, "R7 preempted by device 0");
        step(4'b0000, 1'b0);
        chk(32'(irq_n_o), 32'd0, "R9 device 3 still pending");
        step(4'b0000, 1'b1);
        step(4'b0000, 1'b0);

        // constrained random
        for (int n = 0; n < 2000; n++) begin
            logic [N-1:0] r;
            r = (($urandom % 4) == 0) ? N'($urandom) : '0;
            step(r, ($urandom % 3) == 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule